// File: doc/BRIEF.md
# Configurable Mode GPIO Port

This block is a small general-purpose I/O port of two pins. Software programs one data register and two mode registers. For each pin, the bit pair taken from the two mode registers picks one of four drive styles. The block turns the effective data bit and the selected style into three drive enables per pin, which go to a pad model: strong high, strong low and weak pull-up. The pad levels come back through a two-flop synchronizer and can be read at their own address, apart from the data register.

Software writes a whole register with a byte write. A separate bit-write strobe changes a single pin's data bit. A control register holds a clock-output enable. While it is set, pin 0 takes a divide-by-two copy of the core clock in place of its data bit, and pin 1 is left alone. All control pins are plain strobes with no handshake. A write is taken on the rising edge where its strobe is high. Reads are combinational from the read address.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the data register reads 0x03, both mode registers read 0x00 and the control register reads 0x00. With those values every pin is quasi-bidirectional and drives only its weak pull-up.
- R2: A byte write stores the written value at address 0 (data), 1 (mode register A), 2 (mode register B) or 3 (control, bit 0 = clock-output enable). A read at the same address returns the stored value in the low bits and zeros above them.
- R3: A bit write (bit_wr_en, bit_idx, bit_val) sets data bit bit_idx to bit_val and leaves the other data bit unchanged. When a byte write to address 0 happens in the same cycle, the byte write wins.
- R4: For mode pair {A[x],B[x]} = 01 (push-pull), data 1 gives strong high only and data 0 gives strong low only.
- R5: For mode pair 11 (open-drain), data 0 gives strong low only and data 1 turns off all three enables.
- R6: For mode pair 10 (input-only), all three enables are off for either data value.
- R7: For mode pair 00 (quasi-bidirectional), data 0 gives strong low and data 1 gives the weak pull-up. A 0-to-1 change of the data bit also turns on strong high for exactly two cycles, starting in the cycle right after the edge that stores the new bit.
- R8: A read at address 4 returns the pad_in levels as they were two rising edges earlier.
- R9: While the control enable is set, pin 0's effective data is a register that is 0 in the first cycle after the enable is stored and that inverts on every rising edge after that. Pin 1 keeps following its data bit. Clearing the enable gives pin 0 back its data bit.
- R10: A byte write to address 4 or above changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_addr | input | 3 | Byte write address |
| reg_wdata | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Data bit write strobe |
| bit_idx | input | 1 | Pin index for a bit write |
| bit_val | input | 1 | Value for a bit write |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| pad_in | input | 2 | Levels seen on the pads |
| drv_hi | output | 2 | Strong high enable per pin |
| drv_lo | output | 2 | Strong low enable per pin |
| pull_up | output | 2 | Weak pull-up enable per pin |

## Verification
Several behaviours are checked by assertions on every cycle: the push-pull pin always drives exactly one strong direction, and the open-drain pin never drives high. The input-only pin has every enable off. The quasi-bidirectional boost never runs longer than its two cycles. The synchronizer lag, the divider's start-low-then-invert pattern, the single-bit effect of a bit write and the fact that high addresses are ignored are also asserted. Other behaviours can only be shown by the bench's scenarios: the reset values, the byte readback at each address, the exact cycle in which the boost starts and ends, the two-cycle delay seen at the read port, and pin 0 returning to its data when the clock output is switched off.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_PUSH  = 2'b01,
    PM_INPUT = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODEA = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODEB = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PINS  = 3'd4;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 2,
  parameter int DW    = 8,
  parameter int IDXW  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              bit_wr_en,
  input  logic [IDXW-1:0]   bit_idx,
  input  logic              bit_val,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NPINS-1:0]  pin_lvl,
  output logic [DW-1:0]     rd_data,
  output logic [NPINS-1:0]  data_q,
  output logic [NPINS-1:0]  mode_a_q,
  output logic [NPINS-1:0]  mode_b_q,
  output logic              ckout_en
);
  logic wdata_unused;
  assign wdata_unused = ^wr_data[DW-1:NPINS];

  logic byte_to_data;
  assign byte_to_data = wr_en && (wr_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '1;
      mode_a_q <= '0;
      mode_b_q <= '0;
      ckout_en <= 1'b0;
    end else begin
      if (byte_to_data) begin
        data_q <= wr_data[NPINS-1:0];
      end else if (bit_wr_en) begin
        for (int i = 0; i < NPINS; i++) begin
          if (bit_idx == IDXW'(i)) data_q[i] <= bit_val;
        end
      end
      if (wr_en && wr_addr == A_MODEA) mode_a_q <= wr_data[NPINS-1:0];
      if (wr_en && wr_addr == A_MODEB) mode_b_q <= wr_data[NPINS-1:0];
      if (wr_en && wr_addr == A_CTRL)  ckout_en <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DATA:  rd_data[NPINS-1:0] = data_q;
      A_MODEA: rd_data[NPINS-1:0] = mode_a_q;
      A_MODEB: rd_data[NPINS-1:0] = mode_b_q;
      A_CTRL:  rd_data[0]         = ckout_en;
      A_PINS:  rd_data[NPINS-1:0] = pin_lvl;
      default: rd_data = '0;
    endcase
  end

  AST_BIT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr_en && !byte_to_data) |=> data_q[$past(bit_idx)] == $past(bit_val)); // R3

  AST_BIT_WRITE_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr_en && !byte_to_data) |=>
      ((data_q ^ $past(data_q)) & ~(NPINS'(1) << $past(bit_idx))) == '0); // R3

  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > A_CTRL && !bit_wr_en) |=>
      ($stable(data_q) && $stable(mode_a_q) && $stable(mode_b_q) && $stable(ckout_en))); // R10
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_lvl
);
  logic [NPINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= '0;
      pin_lvl <= '0;
    end else begin
      stage1  <= pad_in;
      pin_lvl <= stage1;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_SYNC_TWO_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> pin_lvl == $past(pad_in, 2)); // R8
endmodule

// File: rtl/gpio_clkdiv.sv
module gpio_clkdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  div_q <= 1'b0;
    else if (en) div_q <= ~div_q;
    else         div_q <= 1'b0;
  end

  AST_DIV_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !div_q); // R9

  AST_DIV_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> div_q != $past(div_q)); // R9
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_port_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      dat,
  output logic      hi,
  output logic      lo,
  output logic      pu
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic          prev_q;
  logic [CW-1:0] left_q;
  logic          rise;
  logic          boost;

  assign rise  = dat && !prev_q;
  assign boost = dat && (rise || left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      left_q <= '0;
    end else begin
      prev_q <= dat;
      if (rise)               left_q <= CW'(PULSE_CYC - 1);
      else if (left_q != '0)  left_q <= left_q - CW'(1);
    end
  end

  always_comb begin
    hi = 1'b0;
    lo = 1'b0;
    pu = 1'b0;
    unique case (mode)
      PM_QUASI: begin hi = boost; lo = !dat; pu = dat; end
      PM_PUSH:  begin hi = dat;   lo = !dat;           end
      PM_INPUT: begin                                  end
      PM_OPEN:  begin             lo = !dat;           end
      default:  begin                                  end
    endcase
  end

  logic [CW:0] qb_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               qb_run <= '0;
    else if (!(hi && mode == PM_QUASI))       qb_run <= '0;
    else if (qb_run != {(CW+1){1'b1}})        qb_run <= qb_run + 1'b1;
  end

  AST_QB_BOOST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    qb_run <= (CW+1)'(PULSE_CYC)); // R7

  AST_PP_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_PUSH) |-> (hi != lo) && !pu); // R4

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OPEN) |-> !hi && !pu); // R5

  AST_IN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_INPUT) |-> $countones({hi, lo, pu}) == 0); // R6
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS     = 2,
  parameter int DW        = 8,
  parameter int PULSE_CYC = 2,
  localparam int IDXW     = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              bit_wr_en,
  input  logic [IDXW-1:0]   bit_idx,
  input  logic              bit_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  drv_hi,
  output logic [NPINS-1:0]  drv_lo,
  output logic [NPINS-1:0]  pull_up
);
  logic [NPINS-1:0] data_q, mode_a_q, mode_b_q, pin_lvl, eff_dat;
  logic             ckout_en, div_q;

  gpio_regs #(.NPINS(NPINS), .DW(DW), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val),
    .rd_addr(rd_addr), .pin_lvl(pin_lvl), .rd_data(rd_data),
    .data_q(data_q), .mode_a_q(mode_a_q), .mode_b_q(mode_b_q),
    .ckout_en(ckout_en)
  );

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_lvl(pin_lvl)
  );

  gpio_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .en(ckout_en), .div_q(div_q)
  );

  always_comb begin
    eff_dat = data_q;
    if (ckout_en) eff_dat[0] = div_q;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'({mode_a_q[g], mode_b_q[g]});
    gpio_pin_drv #(.PULSE_CYC(PULSE_CYC)) u_drv (
      .clk(clk), .rst_n(rst_n), .mode(mode), .dat(eff_dat[g]),
      .hi(drv_hi[g]), .lo(drv_lo[g]), .pu(pull_up[g])
    );
  end

  AST_PIN1_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (NPINS > 1 && mode_a_q[NPINS-1] == 1'b0 && mode_b_q[NPINS-1] == 1'b1) |->
      drv_hi[NPINS-1] == data_q[NPINS-1]); // R9
endmodule

// File: tb/gpio_mode_port_bench.sv
`timescale 1ns/1ps
module gpio_mode_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       bit_wr_en = 1'b0;
  logic [0:0] bit_idx = '0;
  logic       bit_val = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] pad_in = '0;
  logic [1:0] drv_hi, drv_lo, pull_up;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mode_port u_gpio_mode_port (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bit_wr_en(bit_wr_en), .bit_idx(bit_idx),
    .bit_val(bit_val), .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .pull_up(pull_up)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] drv();
    return {2'b00, drv_hi, drv_lo, pull_up};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bwr(input logic i, input logic v);
    @(negedge clk);
    bit_wr_en = 1'b1; bit_idx = i; bit_val = v;
    @(negedge clk);
    bit_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); chk("R1 data reset", v, 8'h03);
    rd(3'd1, v); chk("R1 mode A reset", v, 8'h00);
    rd(3'd2, v); chk("R1 mode B reset", v, 8'h00);
    rd(3'd3, v); chk("R1 ctrl reset", v, 8'h00);
    chk("R1 reset drive pull-up only", drv(), 8'b00_00_00_11);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd1, 8'h02); wr(3'd2, 8'h01); wr(3'd0, 8'h01); wr(3'd3, 8'h00);
    rd(3'd1, v); chk("R2 mode A readback", v, 8'h02);
    rd(3'd2, v); chk("R2 mode B readback", v, 8'h01);
    rd(3'd0, v); chk("R2 data readback", v, 8'h01);
    wr(3'd0, 8'hFE);
    rd(3'd0, v); chk("R2 data high bits read zero", v, 8'h02);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_bitwr();
    logic [7:0] v;
    wr(3'd0, 8'h03);
    bwr(1'b1, 1'b0); rd(3'd0, v); chk("R3 clear bit1", v, 8'h01);
    bwr(1'b0, 1'b0); rd(3'd0, v); chk("R3 clear bit0", v, 8'h00);
    bwr(1'b1, 1'b1); rd(3'd0, v); chk("R3 set bit1", v, 8'h02);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01;
    bit_wr_en = 1'b1; bit_idx = 1'b1; bit_val = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; bit_wr_en = 1'b0;
    rd(3'd0, v); chk("R3 byte write wins", v, 8'h01);
  endtask

  task automatic t_push();
    wr(3'd1, 8'h00); wr(3'd2, 8'h03); wr(3'd0, 8'h02);
    chk("R4 push-pull drive", drv(), 8'b00_10_01_00);
    wr(3'd0, 8'h01);
    chk("R4 push-pull swapped", drv(), 8'b00_01_10_00);
  endtask

  task automatic t_open();
    wr(3'd1, 8'h03); wr(3'd2, 8'h03); wr(3'd0, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 open-drain drive", drv(), 8'b00_00_10_00);
  endtask

  task automatic t_input();
    wr(3'd1, 8'h03); wr(3'd2, 8'h00); wr(3'd0, 8'h00);
    chk("R6 input-only data 0", drv(), 8'h00);
    wr(3'd0, 8'h03);
    chk("R6 input-only data 1", drv(), 8'h00);
  endtask

  task automatic t_quasi();
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h00);
    @(negedge clk);
    chk("R7 quasi low", drv(), 8'b00_00_11_00);
    bwr(1'b0, 1'b1);
    chk("R7 boost cycle 1", drv(), 8'b00_01_10_01);
    @(negedge clk);
    chk("R7 boost cycle 2", drv(), 8'b00_01_10_01);
    @(negedge clk);
    chk("R7 boost ended", drv(), 8'b00_00_10_01);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk); pad_in = 2'b00;
    repeat (3) @(negedge clk);
    pad_in = 2'b10;
    rd(3'd4, v); chk("R8 before edges", v, 8'h00);
    @(negedge clk); rd(3'd4, v); chk("R8 after one edge", v, 8'h00);
    @(negedge clk); rd(3'd4, v); chk("R8 after two edges", v, 8'h02);
    pad_in = 2'b01;
    @(negedge clk); @(negedge clk); rd(3'd4, v); chk("R8 second pattern", v, 8'h01);
  endtask

  task automatic t_ckout();
    logic [7:0] v;
    wr(3'd1, 8'h00); wr(3'd2, 8'h03); wr(3'd0, 8'h03);
    wr(3'd3, 8'h01);
    rd(3'd3, v); chk("R2 ctrl readback", v, 8'h01);
    chk("R9 clock out starts low", drv(), 8'b00_10_01_00);
    @(negedge clk);
    chk("R9 clock out high", drv(), 8'b00_11_00_00);
    @(negedge clk);
    chk("R9 clock out low again", drv(), 8'b00_10_01_00);
    wr(3'd3, 8'h00);
    chk("R9 pin0 back to data", drv(), 8'b00_11_00_00);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd2, 8'h02); wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF); wr(3'd5, 8'h00); wr(3'd7, 8'hFF);
    rd(3'd0, v); chk("R10 data untouched", v, 8'h02);
    rd(3'd1, v); chk("R10 mode A untouched", v, 8'h01);
    rd(3'd2, v); chk("R10 mode B untouched", v, 8'h02);
    rd(3'd3, v); chk("R10 ctrl untouched", v, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bitwr();
    t_push();
    t_open();
    t_input();
    t_quasi();
    t_sync();
    t_ckout();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule